// File: doc/BRIEF.md
# Flash Hardware Reset Sequencer

This block handles the external reset pin of a parallel flash device's control logic. It runs on a free-running clock. The pin is active-low and asynchronous, so the block first passes it through a two-flop synchronizer. It then measures how long each low pulse lasts.

A pulse that meets the minimum width is treated as a real reset. A fixed delay after the pulse began, the block emits a one-cycle abort strobe. That strobe terminates any embedded program or erase and returns the command state machine to read mode. The abort happens even if the pin has already returned high. Shorter pulses are treated as glitches and cause no abort.

While the pin is held low, the block reports standby. Read access, which also gates the data output drivers, stays blocked from the start of the pulse until a recovery time has passed after release. If the abort lands while an embedded operation is busy, a sticky flag records that the target location is corrupt. Only the block's own reset clears that flag.

All three timings are given in picoseconds together with the clock period. Each is converted to a cycle count by rounding up. The defaults are:

- a 500 ns minimum width, which is 100 cycles at 5 ns;
- a 20 us abort delay, which is 4000 cycles;
- a 50 ns recovery time, which is 10 cycles.

Top module: `flash_rst_seq`

## Requirements
- R1: After `rst_n` is released with the pin high, `standby`=0, `rd_allow`=1, `abort_stb`=0 and `corrupt`=0.
- R2: Number the rising edges from edge 1, the first edge that samples the pin low. `standby` is low after edge 1. It is high after edges 2 through W+1, where W is the number of edges that sampled the pin low. It is low again after edge W+2.
- R3: A pulse with W below MIN_CYC = ceil(500 ns / clock period) produces no `abort_stb`.
- R4: A pulse with W of at least MIN_CYC produces exactly one `abort_stb` cycle, visible after edge ABORT_CYC+2, where ABORT_CYC = ceil(20 us / clock period). This holds when the pin is still low at that edge.
- R5: A pulse that has met MIN_CYC and is released before the abort delay ends still gives its single `abort_stb` at edge ABORT_CYC+2.
- R6: `rd_allow` is low after edge 2. Let REC_CYC = ceil(50 ns / clock period). After an unqualified pulse, `rd_allow` rises after edge W+3+REC_CYC. After a qualified pulse, it rises after edge max(ABORT_CYC+2, W+3)+REC_CYC.
- R7: `corrupt` is set at the abort edge if `busy_op` is high there. It then stays set across later pulses, and only `rst_n` clears it.
- R8: `abort_stb` never lasts more than one cycle, and `rd_allow` is never high while `standby` is high.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Free-running clock |
| rst_n | input | 1 | Block reset, asynchronous assert, active low |
| pin_rst_n | input | 1 | External reset pin, asynchronous, active low |
| busy_op | input | 1 | An embedded program or erase is in progress |
| standby | output | 1 | Device is in standby while the synchronized pin is low |
| rd_allow | output | 1 | Read access and data output drivers permitted |
| abort_stb | output | 1 | One-cycle strobe: terminate operation, force read mode |
| corrupt | output | 1 | Sticky: a reset hit a busy program or erase |

## Verification
The pulse widths are chosen to separate the two qualification outcomes:

- a narrow glitch;
- a pulse exactly one cycle short of the minimum width, which must be ignored;
- pulses exactly at and one cycle past the minimum width, which must abort;
- a pulse released well inside the abort delay;
- a pulse still held when the abort fires.

Each width predicts its own edge for the abort and for the return of read access. Those predictions tell the recovery-after-release path apart from the recovery-after-abort path. Running the busy input low and then high on otherwise identical pulses shows that the corrupt flag follows the abort together with the busy input. A final short pulse shows that the flag stays set.

// File: rtl/flr_pkg.sv
`timescale 1ns/1ps
package flr_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,   // pin high, reads allowed
    ST_LOW,    // pin low, width not yet qualified
    ST_QUAL,   // qualified, abort delay running
    ST_HOLD,   // abort done, pin still low
    ST_RECOV   // released, read recovery running
  } flr_state_e;

  function automatic int ps_to_cyc(input int ps, input int clk_ps);
    return (ps + clk_ps - 1) / clk_ps;
  endfunction

endpackage

// File: rtl/flr_sync2.sv
`timescale 1ns/1ps
module flr_sync2 (
  input  logic clk,
  input  logic rst_n,
  input  logic d,
  output logic q
);
  logic [1:0] stage_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) stage_q <= 2'b11;
    else        stage_q <= {stage_q[0], d};
  end

  assign q = stage_q[1];
endmodule

// File: rtl/flr_sat_cnt.sv
`timescale 1ns/1ps
module flr_sat_cnt #(
  parameter int W        = 8,
  parameter int MAX      = 200,
  parameter int LOAD_VAL = 0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load,
  input  logic         inc,
  output logic [W-1:0] cnt
);
  logic [W-1:0] cnt_q, cnt_d;
  logic         en;

  assign en = load | inc;

  always_comb begin
    cnt_d = cnt_q;
    if (load)                      cnt_d = W'(LOAD_VAL);
    else if (cnt_q != W'(MAX))     cnt_d = cnt_q + W'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)  cnt_q <= '0;
    else if (en) cnt_q <= cnt_d;
  end

  assign cnt = cnt_q;
endmodule

// File: rtl/flash_rst_seq.sv
`timescale 1ns/1ps
module flash_rst_seq #(
  parameter int CLK_PS       = 5000,
  parameter int MIN_PULSE_PS = 500_000,
  parameter int ABORT_DLY_PS = 20_000_000,
  parameter int RECOVER_PS   = 50_000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic pin_rst_n,
  input  logic busy_op,
  output logic standby,
  output logic rd_allow,
  output logic abort_stb,
  output logic corrupt
);
  import flr_pkg::*;

  localparam int MIN_CYC   = ps_to_cyc(MIN_PULSE_PS, CLK_PS);
  localparam int ABORT_CYC = ps_to_cyc(ABORT_DLY_PS, CLK_PS);
  localparam int REC_CYC   = (ps_to_cyc(RECOVER_PS, CLK_PS) < 1) ? 1
                             : ps_to_cyc(RECOVER_PS, CLK_PS);
  localparam int EW        = $clog2(ABORT_CYC + 1);
  localparam int RW        = (REC_CYC > 1) ? $clog2(REC_CYC) : 1;

  logic pin_s, low_s;
  logic [EW-1:0] el_cnt;
  logic [RW-1:0] rc_cnt;
  logic el_load, el_inc, rc_load, rc_inc, fire;
  flr_state_e st_q, st_d;
  logic abort_q, corrupt_q, corrupt_d;

  flr_sync2 u_sync (
    .clk(clk), .rst_n(rst_n), .d(pin_rst_n), .q(pin_s)
  );
  assign low_s = ~pin_s;

  // cycles since the synchronized pin was first seen low; saturates
  flr_sat_cnt #(.W(EW), .MAX(ABORT_CYC), .LOAD_VAL(1)) u_elapsed (
    .clk(clk), .rst_n(rst_n), .load(el_load), .inc(el_inc), .cnt(el_cnt)
  );

  // read recovery cycles after release
  flr_sat_cnt #(.W(RW), .MAX(REC_CYC - 1), .LOAD_VAL(0)) u_recov (
    .clk(clk), .rst_n(rst_n), .load(rc_load), .inc(rc_inc), .cnt(rc_cnt)
  );

  always_comb begin
    st_d    = st_q;
    el_load = 1'b0;
    el_inc  = 1'b0;
    rc_load = 1'b0;
    rc_inc  = 1'b0;
    fire    = 1'b0;
    unique case (st_q)
      ST_IDLE: if (low_s) begin
        st_d    = ST_LOW;
        el_load = 1'b1;
      end
      ST_LOW: begin
        if (!low_s) begin
          st_d    = ST_RECOV;
          rc_load = 1'b1;
        end else begin
          el_inc = 1'b1;
          if (el_cnt >= EW'(MIN_CYC - 1)) st_d = ST_QUAL;
        end
      end
      ST_QUAL: begin
        el_inc = 1'b1;
        if (el_cnt == EW'(ABORT_CYC - 1)) begin
          fire = 1'b1;
          if (low_s) st_d = ST_HOLD;
          else begin
            st_d    = ST_RECOV;
            rc_load = 1'b1;
          end
        end
      end
      ST_HOLD: if (!low_s) begin
        st_d    = ST_RECOV;
        rc_load = 1'b1;
      end
      ST_RECOV: begin
        if (low_s) begin
          st_d    = ST_LOW;
          el_load = 1'b1;
        end else if (rc_cnt == RW'(REC_CYC - 1)) begin
          st_d = ST_IDLE;
        end else begin
          rc_inc = 1'b1;
        end
      end
      default: st_d = ST_IDLE;
    endcase
  end

  assign corrupt_d = corrupt_q | (fire & busy_op);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q      <= ST_IDLE;
      abort_q   <= 1'b0;
      corrupt_q <= 1'b0;
    end else begin
      st_q      <= st_d;
      abort_q   <= fire;
      corrupt_q <= corrupt_d;
    end
  end

  assign standby   = low_s;
  assign rd_allow  = (st_q == ST_IDLE) & ~low_s;
  assign abort_stb = abort_q;
  assign corrupt   = corrupt_q;
endmodule

// File: rtl/flash_rst_seq_chk.sv
`timescale 1ns/1ps
module flash_rst_seq_chk (
  input logic clk,
  input logic rst_n,
  input logic standby,
  input logic rd_allow,
  input logic abort_stb,
  input logic corrupt
);
  // R8
  abort_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    abort_stb |=> !abort_stb);

  // R8
  standby_blocks_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
    standby |-> !rd_allow);

  // R7
  corrupt_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    corrupt |=> corrupt);

  // R7
  corrupt_on_abort_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(corrupt) |-> abort_stb);

  // R6
  abort_blocks_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
    abort_stb |-> !rd_allow);
endmodule

bind flash_rst_seq flash_rst_seq_chk u_chk (
  .clk(clk), .rst_n(rst_n), .standby(standby),
  .rd_allow(rd_allow), .abort_stb(abort_stb), .corrupt(corrupt)
);

// File: tb/flash_rst_seq_test.sv
`timescale 1ns/1ps
module flash_rst_seq_test;
  localparam int CLK_PS = 5000;
  localparam int MIN_C  = (500_000 + CLK_PS - 1) / CLK_PS;
  localparam int ABT_C  = (20_000_000 + CLK_PS - 1) / CLK_PS;
  localparam int REC_C  = (50_000 + CLK_PS - 1) / CLK_PS;
  localparam int NV     = 8;

  // width in low-sampled edges, busy level, abort expected, corrupt after
  localparam int V_WIDTH [NV] = '{3, MIN_C-1, MIN_C, MIN_C+1, MIN_C+50,
                                  ABT_C+20, MIN_C, 5};
  localparam bit V_BUSY  [NV] = '{1, 1, 0, 0, 0, 0, 1, 0};
  localparam bit V_ABT   [NV] = '{0, 0, 1, 1, 1, 1, 1, 0};
  localparam bit V_COR   [NV] = '{0, 0, 0, 0, 0, 0, 1, 1};

  logic clk = 1'b0;
  logic rst_n, pin_rst_n, busy_op;
  logic standby, rd_allow, abort_stb, corrupt;
  int   n_chk = 0;
  int   n_bad = 0;
  bit   done  = 1'b0;

  always #2.5 clk = ~clk;

  flash_rst_seq uut (
    .clk(clk), .rst_n(rst_n), .pin_rst_n(pin_rst_n), .busy_op(busy_op),
    .standby(standby), .rd_allow(rd_allow), .abort_stb(abort_stb),
    .corrupt(corrupt)
  );

  task automatic chk(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic run_pulse(input int w, input bit busy, input bit exp_abt,
                           input bit exp_cor);
    int first_ab = -1;
    int n_ab     = 0;
    int rise     = -1;
    bit prev     = 1'b1;
    int exp_rise;
    int stop;
    if (exp_abt)
      exp_rise = ((ABT_C + 2 > w + 3) ? ABT_C + 2 : w + 3) + REC_C;
    else
      exp_rise = w + 3 + REC_C;
    stop = exp_rise + 8;
    @(negedge clk);
    busy_op   = busy;
    pin_rst_n = 1'b0;
    for (int e = 1; e <= stop; e++) begin
      @(posedge clk);
      @(negedge clk);
      if (e == w) pin_rst_n = 1'b1;
      if (abort_stb) begin
        n_ab++;
        if (first_ab < 0) first_ab = e;
      end
      if (rd_allow && !prev) rise = e;
      prev = rd_allow;
      if (e == 1)     chk("R2 standby edge1", int'(standby), 0);
      if (e == 2) begin
        chk("R2 standby edge2", int'(standby), 1);
        chk("R6 rd_allow edge2", int'(rd_allow), 0);
      end
      if (e == w + 1) chk("R2 standby last", int'(standby), 1);
      if (e == w + 2) chk("R2 standby drop", int'(standby), 0);
    end
    if (!exp_abt) chk("R3 abort count", n_ab, 0);
    else begin
      chk("R4 abort count", n_ab, 1);
      if (w < ABT_C) chk("R5 abort edge", first_ab, ABT_C + 2);
      else           chk("R4 abort edge", first_ab, ABT_C + 2);
    end
    chk("R6 read recovery edge", rise, exp_rise);
    chk("R7 corrupt", int'(corrupt), int'(exp_cor));
    busy_op = 1'b0;
  endtask

  initial begin
    rst_n     = 1'b0;
    pin_rst_n = 1'b1;
    busy_op   = 1'b0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 standby", int'(standby), 0);
    chk("R1 rd_allow", int'(rd_allow), 1);
    chk("R1 abort_stb", int'(abort_stb), 0);
    chk("R1 corrupt", int'(corrupt), 0);

    for (int v = 0; v < NV; v++)
      run_pulse(V_WIDTH[v], V_BUSY[v], V_ABT[v], V_COR[v]);

    // directed: only the block reset clears the corrupt flag
    @(negedge clk);
    rst_n = 1'b0;
    @(negedge clk);
    chk("R7 corrupt cleared", int'(corrupt), 0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    chk("R7 corrupt stays clear", int'(corrupt), 0);
    chk("R1 rd_allow after reset", int'(rd_allow), 1);

    if (!done) begin
      done = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (200_000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      n_bad++;
      $display("FAIL watchdog R1-chain actual=%0d expected=%0d", 1, 0);
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end
endmodule